// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block watches a free-running timer and compares it with a programmable compare value. When the two become equal, it performs one of four actions chosen by a 4-bit mode field. It can set an output latch high, clear that latch low, raise only the match interrupt flag, or fire an event trigger. The event trigger tells the external timer to restart from zero, so the compare value becomes a programmable period. A build option also lets the trigger start an ADC conversion.

The timer, its prescaler and the converter are outside the block, and the timer must count in step with the system clock. A one-cycle clear strobe models a write of zero to the control register. It forces the output latch low without touching any general port latch. A direction input decides whether the pin drives. The interrupt flag stays set until a software clear strobe.

Top module: `cmp_event_unit`

## Requirements
- R1: While `rstN` is low, `pinOut`, `pinOe` (with `dirOut` low), `matchFlag`, `timerReset` and `adcStart` are all 0.
- R2: With `modeSel` = 4'b1000, the first clock edge at which `timerVal` equals `cmpVal` sets the output latch to 1, and the change is visible right after that edge.
- R3: A match acts only on entry into equality. If `timerVal` stays equal to `cmpVal` on later edges, there is no new action, so `timerReset` is high for exactly one cycle per entry.
- R4: The match action and the setting of `matchFlag` happen at the same clock edge, in every active mode.
- R5: `matchFlag` is sticky and clears only on an edge where `flagClear` is high. If a new match arrives at that same edge, the flag stays set.
- R6: With `modeSel` = 4'b1001, a match clears the output latch to 0.
- R7: With `modeSel` = 4'b1010, a match sets `matchFlag` and leaves the output latch unchanged.
- R8: With `modeSel` = 4'b1011, a match makes `timerReset` high for one cycle, sets `matchFlag` and leaves the output latch unchanged.
- R9: `adcStart` pulses together with `timerReset` only when `adcEnable` is 1 at the match edge. Otherwise it stays 0.
- R10: An edge with `ctrlClear` high forces the output latch to 0 and suppresses any match action on that edge.
- R11: With `modeSel` = 4'b0000, or any code other than 1000 to 1011, a match changes nothing.
- R12: `pinOe` follows `dirOut`. When `dirOut` is 0, `pinOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerVal | input | 16 | Current timer count |
| cmpVal | input | 16 | Compare value |
| modeSel | input | 4 | Match action select |
| ctrlClear | input | 1 | Control-register clear strobe |
| adcEnable | input | 1 | Converter enabled |
| dirOut | input | 1 | Pin direction, 1 = output |
| flagClear | input | 1 | Software clear of the match flag |
| pinOut | output | 1 | Pin level |
| pinOe | output | 1 | Pin output enable |
| matchFlag | output | 1 | Sticky match interrupt flag |
| timerReset | output | 1 | One-cycle timer restart pulse |
| adcStart | output | 1 | One-cycle conversion start pulse |

## Verification
A stuck or wrong equality history register shows up on the first edge after the timer enters or stays at the compare value. It appears as a missing or repeated `timerReset` pulse and a missing or repeated flag set. A corrupted output latch is visible on `pinOut` right after the match edge when the direction is output. A wrong latch can stay hidden through interrupt-only and trigger matches until the direction bit is read. A broken flag register shows up at the next clear strobe, or at a clear strobe that coincides with a match.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  typedef enum logic [3:0] {
    MODE_OFF      = 4'b0000,
    MODE_SET_HI   = 4'b1000,
    MODE_SET_LO   = 4'b1001,
    MODE_SOFT_IRQ = 4'b1010,
    MODE_EVENT    = 4'b1011
  } cmpMode_e;

  typedef struct packed {
    logic forceLow;
    logic setPin;
    logic clrPin;
    logic raiseFlag;
  } latchStrobe_t;
endpackage

// File: rtl/cmp_evt_datapath.sv
module cmp_evt_datapath
  import cmp_evt_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic [TIMER_W-1:0] cmpVal,
  input  latchStrobe_t       strobe,
  input  logic               flagClear,
  input  logic               dirOut,
  output logic               matchRise,
  output logic               pinOut,
  output logic               pinOe,
  output logic               matchFlag
);
  logic eqNow;
  logic eqPrev;
  logic pinLatch;

  assign eqNow     = (timerVal == cmpVal);
  assign matchRise = eqNow & ~eqPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eqPrev    <= 1'b0;
      pinLatch  <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      eqPrev <= eqNow;
      if (strobe.forceLow || strobe.clrPin) pinLatch <= 1'b0;
      else if (strobe.setPin)               pinLatch <= 1'b1;
      if (strobe.raiseFlag)   matchFlag <= 1'b1;
      else if (flagClear)     matchFlag <= 1'b0;
    end
  end

  assign pinOe  = dirOut;
  assign pinOut = dirOut & pinLatch;
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter bit HAS_ADC = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   modeSel,
  input  logic         matchRise,
  input  logic         ctrlClear,
  input  logic         adcEnable,
  output latchStrobe_t strobe,
  output logic         timerReset,
  output logic         adcStart
);
  logic act;
  logic fireEvent;

  always_comb begin
    strobe          = '0;
    strobe.forceLow = ctrlClear;
    act             = matchRise & ~ctrlClear;
    fireEvent       = 1'b0;
    case (modeSel)
      MODE_SET_HI:   begin strobe.setPin = act; strobe.raiseFlag = act; end
      MODE_SET_LO:   begin strobe.clrPin = act; strobe.raiseFlag = act; end
      MODE_SOFT_IRQ: strobe.raiseFlag = act;
      MODE_EVENT:    begin strobe.raiseFlag = act; fireEvent = act; end
      default:       ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) timerReset <= 1'b0;
    else       timerReset <= fireEvent;
  end

  generate
    if (HAS_ADC) begin : g_adc
      logic adcQ;
      always_ff @(posedge clk) begin
        if (!rstN) adcQ <= 1'b0;
        else       adcQ <= fireEvent & adcEnable;
      end
      assign adcStart = adcQ;
    end else begin : g_noadc
      logic unusedAdc;
      assign unusedAdc = adcEnable;
      assign adcStart  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
  import cmp_evt_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter bit HAS_ADC = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic [TIMER_W-1:0] cmpVal,
  input  logic [3:0]         modeSel,
  input  logic               ctrlClear,
  input  logic               adcEnable,
  input  logic               dirOut,
  input  logic               flagClear,
  output logic               pinOut,
  output logic               pinOe,
  output logic               matchFlag,
  output logic               timerReset,
  output logic               adcStart
);
  latchStrobe_t strobe;
  logic         matchRise;

  cmp_evt_datapath #(.TIMER_W(TIMER_W)) u_dp (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .cmpVal(cmpVal),
    .strobe(strobe), .flagClear(flagClear), .dirOut(dirOut),
    .matchRise(matchRise), .pinOut(pinOut), .pinOe(pinOe),
    .matchFlag(matchFlag)
  );

  cmp_evt_ctrl #(.HAS_ADC(HAS_ADC)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .matchRise(matchRise),
    .ctrlClear(ctrlClear), .adcEnable(adcEnable), .strobe(strobe),
    .timerReset(timerReset), .adcStart(adcStart)
  );
endmodule

// File: rtl/cmp_event_unit_chk.sv
module cmp_event_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] modeSel,
  input logic       ctrlClear,
  input logic       dirOut,
  input logic       flagClear,
  input logic       pinOut,
  input logic       matchFlag,
  input logic       timerReset,
  input logic       adcStart
);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    timerReset |=> !timerReset);
  p_trig_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    timerReset |-> matchFlag);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !flagClear) |=> matchFlag);
  p_adc_with_trig_r9: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> timerReset);
  p_clear_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlClear |=> !pinOut);
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 4'b0000 && !matchFlag) |=> !matchFlag);
  p_dir_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    !dirOut |-> !pinOut);
endmodule

bind cmp_event_unit cmp_event_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .ctrlClear(ctrlClear),
  .dirOut(dirOut), .flagClear(flagClear), .pinOut(pinOut),
  .matchFlag(matchFlag), .timerReset(timerReset), .adcStart(adcStart)
);

// File: tb/sim_cmp_event_unit.sv
module sim_cmp_event_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timerVal = '0;
  logic [15:0] cmpVal = 16'hFFFF;
  logic [3:0]  modeSel = '0;
  logic        ctrlClear = 1'b0, adcEnable = 1'b0, dirOut = 1'b0, flagClear = 1'b0;
  logic        pinOut, pinOe, matchFlag, timerReset, adcStart;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic  pin, oe, flag, tr, adc;
    string tag;
  } expItem_t;
  expItem_t q[$];

  bit mPrevEq = 0, mLatch = 0, mFlag = 0;

  always #10 clk = ~clk;

  cmp_event_unit u0 (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .cmpVal(cmpVal),
    .modeSel(modeSel), .ctrlClear(ctrlClear), .adcEnable(adcEnable),
    .dirOut(dirOut), .flagClear(flagClear), .pinOut(pinOut), .pinOe(pinOe),
    .matchFlag(matchFlag), .timerReset(timerReset), .adcStart(adcStart)
  );

  task automatic cmpField(string tag, string name, logic act, logic exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s actual %0b expected %0b", tag, name, act, exp);
      bad = 1;
    end
  endtask

  task automatic checkItem(expItem_t e);
    bit bad = 0;
    checks++;
    cmpField(e.tag, "pinOut", pinOut, e.pin, bad);
    cmpField(e.tag, "pinOe", pinOe, e.oe, bad);
    cmpField(e.tag, "matchFlag", matchFlag, e.flag, bad);
    cmpField(e.tag, "timerReset", timerReset, e.tr, bad);
    cmpField(e.tag, "adcStart", adcStart, e.adc, bad);
    if (bad) fails++;
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic [15:0] t, input logic [15:0] c, input logic [3:0] m,
                      input bit clr, input bit adcEn, input bit dir, input bit fclr,
                      input string tag);
    bit eq, act;
    expItem_t e;
    @(negedge clk);
    timerVal = t; cmpVal = c; modeSel = m; ctrlClear = clr;
    adcEnable = adcEn; dirOut = dir; flagClear = fclr;
    eq  = (t == c);
    act = eq && !mPrevEq && !clr && (m inside {4'b1000, 4'b1001, 4'b1010, 4'b1011});
    if (clr) mLatch = 0;
    else if (act && m == 4'b1000) mLatch = 1;
    else if (act && m == 4'b1001) mLatch = 0;
    if (act) mFlag = 1;
    else if (fclr) mFlag = 0;
    mPrevEq = eq;
    e.pin = dir & mLatch; e.oe = dir; e.flag = mFlag;
    e.tr = act && m == 4'b1011; e.adc = e.tr && adcEn;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares after each active edge
  initial forever begin
    @(posedge clk); #5;
    if (rstN && q.size() > 0) checkItem(q.pop_front());
  end

  initial begin
    #(20 * 100000);
    $display("FAIL watchdog actual hung expected done");
    checks++; fails++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    expItem_t r;
    repeat (3) @(posedge clk);
    #5;
    r.pin = 0; r.oe = 0; r.flag = 0; r.tr = 0; r.adc = 0; r.tag = "R1 reset";
    checkItem(r);
    @(negedge clk); rstN = 1'b1;
    // R2 / R4: set high on entry into equality
    step(16'd3, 16'd5, 4'b1000, 0, 0, 1, 0, "R2 approach");
    step(16'd4, 16'd5, 4'b1000, 0, 0, 1, 0, "R2 approach");
    step(16'd5, 16'd5, 4'b1000, 0, 0, 1, 0, "R2 R4 set high");
    // R5: clear flag while held equal, R3: no re-trigger
    step(16'd5, 16'd5, 4'b1000, 0, 0, 1, 1, "R5 flag clear");
    step(16'd5, 16'd5, 4'b1000, 0, 0, 1, 0, "R3 held equal no reset");
    // R6: set low
    step(16'd6, 16'd5, 4'b1001, 0, 0, 1, 1, "R5 cleared");
    step(16'd5, 16'd5, 4'b1001, 0, 0, 1, 0, "R6 set low");
    // R7: soft interrupt with latch high
    step(16'd9, 16'h0100, 4'b1000, 0, 0, 1, 1, "R7 prep");
    step(16'h0100, 16'h0100, 4'b1000, 0, 0, 1, 0, "R7 prep high");
    step(16'h0101, 16'h0100, 4'b1010, 0, 0, 1, 1, "R7 prep clear");
    step(16'h0100, 16'h0100, 4'b1010, 0, 0, 1, 0, "R7 soft irq pin kept");
    // R8: event trigger without converter
    step(16'h1233, 16'h1234, 4'b1011, 0, 0, 1, 1, "R8 prep");
    step(16'h1234, 16'h1234, 4'b1011, 0, 0, 1, 0, "R8 trigger");
    step(16'h1234, 16'h1234, 4'b1011, 0, 0, 1, 0, "R3 single pulse");
    // R9: event trigger with converter enabled
    step(16'h0000, 16'hFFFF, 4'b1011, 0, 1, 1, 1, "R9 prep");
    step(16'hFFFF, 16'hFFFF, 4'b1011, 0, 1, 1, 0, "R9 adc start");
    step(16'h0000, 16'hFFFF, 4'b1011, 0, 1, 1, 0, "R9 pulse ends");
    // R5: clear coinciding with match, set wins
    step(16'hFFFF, 16'hFFFF, 4'b1010, 0, 0, 1, 1, "R5 set beats clear");
    // R10: control clear forces low and blocks action
    step(16'd0, 16'd7, 4'b1000, 1, 0, 1, 1, "R10 clear latch");
    step(16'd7, 16'd7, 4'b1000, 1, 0, 1, 0, "R10 match suppressed");
    step(16'd8, 16'd7, 4'b1000, 0, 0, 1, 0, "R10 after");
    // R11: disabled and unused codes
    step(16'd7, 16'd7, 4'b0000, 0, 0, 1, 0, "R11 mode off");
    step(16'd8, 16'd7, 4'b1100, 0, 0, 1, 0, "R11 prep");
    step(16'd7, 16'd7, 4'b1100, 0, 0, 1, 0, "R11 unused code");
    // R12: direction gating
    step(16'd8, 16'd7, 4'b1000, 0, 0, 0, 0, "R12 prep");
    step(16'd7, 16'd7, 4'b1000, 0, 0, 0, 0, "R12 input dir");
    step(16'd7, 16'd7, 4'b1000, 0, 0, 1, 0, "R12 output dir shows latch");
    step(16'd7, 16'd7, 4'b1000, 0, 0, 1, 0, "R3 idle");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule